// File: doc/BRIEF.md
# Bus-Mapped GPIO Line Controller

This block gives a parameterised set of general-purpose I/O lines, at most 256, each with its own 8-bit control byte. A Wishbone slave port with a wide data bus reaches the control bytes. Each data word carries one byte per lane, so a 64-bit bus covers eight lines in one transaction. Lines are grouped by address: one group holds as many lines as the bus has byte lanes. A line's byte sits in the lane given by its index within the group. The group advances with each multiple of the lane count in the byte address.

Each control byte holds a 3-bit bank select, an I/O data bit, pull-down and pull-up enables, and input and output path enables. The stored fields drive the pad-side outputs directly from flops. Bank 0 means the line is run entirely from the bus. Other bank codes pass to the pad multiplexer outside this block. The I/O bit has two meanings on read-back. It returns the driven output value when the output path is on. It returns the synchronised pad level when only the input path is on. It returns 0 when both paths are off.

Top module: `gpio_csr_bank`

## Requirements
- R1: Reset is synchronous and active high. It clears every control byte, so all pad outputs are 0 and wb_ack is low in the cycle after reset.
- R2: wb_ack rises one cycle after a cycle where wb_cyc and wb_stb are both high and wb_ack is low. It stays high for exactly one cycle.
- R3: Control byte layout is: bits 7:5 bank select, bit 4 I/O data, bit 3 pull-down enable, bit 2 pull-up enable, bit 1 input enable, bit 0 output enable. Line n drives pad_out[n], pad_pd[n], pad_pu[n] and pad_oe[n] from bits 4, 3, 2 and 0. It drives pad_bank[3n+2:3n] from bits 7:5.
- R4: When the output enable is 1, a read of bit 4 returns the stored output value, whatever the pad input.
- R5: When the output enable is 0 and the input enable is 1, a read of bit 4 returns pad_in through a two-flop synchroniser. A change is seen by a read acknowledged on the third rising edge after it, or later. A read acknowledged on the first such edge still returns the old level.
- R6: When both enables are 0, a read of bit 4 returns 0. The stored output value still drives pad_out.
- R7: Bits 7:5 and 3:0 read back exactly as last written.
- R8: On a write, only the lanes whose wb_sel bit is 1 update their control bytes. The other lines keep their bytes.
- R9: Line n sits in group n/8 (for 64-bit data), lane n%8, in data bits 8*(n%8)+7 down to 8*(n%8). The group is wb_adr divided by the lane count. The low address bits select nothing.
- R10: Lanes and groups beyond NUM_LINES read as zero. Writes to them change no existing line.
- R11: Control bytes and pad outputs change only on a write request. Idle cycles, cycles with only one of wb_cyc and wb_stb high, and reads leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc | input | 1 | Bus cycle valid |
| wb_stb | input | 1 | Strobe |
| wb_we | input | 1 | Write enable |
| wb_adr | input | ADDR_W | Byte address; upper bits pick the line group |
| wb_sel | input | DATA_W/8 | Byte-lane write selects |
| wb_dat_w | input | DATA_W | Write data, one control byte per lane |
| wb_dat_r | output | DATA_W | Read data, one status byte per lane |
| wb_ack | output | 1 | One-cycle acknowledge |
| pad_in | input | NUM_LINES | Asynchronous pad input levels |
| pad_out | output | NUM_LINES | Output value per line |
| pad_oe | output | NUM_LINES | Output enable per line |
| pad_pu | output | NUM_LINES | Pull-up enable per line |
| pad_pd | output | NUM_LINES | Pull-down enable per line |
| pad_bank | output | 3*NUM_LINES | Bank select, three bits per line |

## Verification
Several properties are checked on every cycle: the acknowledge timing and its single-cycle width, the cleared outputs after reset, and the rule that pad outputs hold still through idle cycles, half-asserted strobes, reads and writes with no lane selected. The bench's scenarios cover what needs known data. This includes the field positions and lane placement, the two-meaning read-back of the I/O bit under each enable setting, the synchroniser delay, partial byte-select writes, and the zero read-back of lines beyond the configured count.

// File: rtl/gpio_csr_pkg.sv
package gpio_csr_pkg;

  localparam int CSR_W  = 8;
  localparam int BANK_W = 3;

  // One control byte per line, MSB first.
  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic              io;
    logic              pden;
    logic              puen;
    logic              ie;
    logic              oe;
  } csr_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;

endmodule

// File: rtl/gpio_wb_port.sv
module gpio_wb_port #(
  parameter int ADDR_W    = 8,
  parameter int LANE_BITS = 3,
  localparam int GRP_W    = ADDR_W - LANE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc,
  input  logic              stb,
  input  logic              we,
  input  logic [ADDR_W-1:0] adr,
  output logic              ack,
  output logic              wr_go,
  output logic              rd_go,
  output logic [GRP_W-1:0]  grp
);

  logic req;
  logic unused_low_adr;

  assign req   = cyc && stb && !ack;
  assign wr_go = req && we;
  assign rd_go = req && !we;
  assign grp   = adr[ADDR_W-1:LANE_BITS];
  assign unused_low_adr = ^adr[LANE_BITS-1:0];

  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b0;
    else     ack <= req;
  end

endmodule

// File: rtl/gpio_line.sv
module gpio_line
  import gpio_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_byte,
  input  logic             pin_sync,
  output csr_t             state,
  output logic [CSR_W-1:0] rd_byte
);

  csr_t view;

  always_ff @(posedge clk) begin
    if (rst)        state <= '0;
    else if (wr_en) state <= csr_t'(wr_byte);
  end

  // The I/O bit shows the driven value first, then the pad, else zero.
  always_comb begin
    view = state;
    if (state.oe)      view.io = state.io;
    else if (state.ie) view.io = pin_sync;
    else               view.io = 1'b0;
  end

  assign rd_byte = view;

endmodule

// File: rtl/gpio_csr_bank.sv
module gpio_csr_bank
  import gpio_csr_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 8,
  localparam int LANES     = DATA_W / CSR_W,
  localparam int LANE_BITS = $clog2(LANES),
  localparam int GRP_W     = ADDR_W - LANE_BITS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wb_cyc,
  input  logic                        wb_stb,
  input  logic                        wb_we,
  input  logic [ADDR_W-1:0]           wb_adr,
  input  logic [LANES-1:0]            wb_sel,
  input  logic [DATA_W-1:0]           wb_dat_w,
  output logic [DATA_W-1:0]           wb_dat_r,
  output logic                        wb_ack,
  input  logic [NUM_LINES-1:0]        pad_in,
  output logic [NUM_LINES-1:0]        pad_out,
  output logic [NUM_LINES-1:0]        pad_oe,
  output logic [NUM_LINES-1:0]        pad_pu,
  output logic [NUM_LINES-1:0]        pad_pd,
  output logic [BANK_W*NUM_LINES-1:0] pad_bank
);

  logic             wr_go;
  logic             rd_go;
  logic [GRP_W-1:0] grp;
  logic [NUM_LINES-1:0] pin_sync;
  logic [CSR_W-1:0] rb [NUM_LINES];
  csr_t             st [NUM_LINES];
  logic [DATA_W-1:0] rd_word;

  gpio_wb_port #(
    .ADDR_W   (ADDR_W),
    .LANE_BITS(LANE_BITS)
  ) u_port (
    .clk  (clk),
    .rst  (rst),
    .cyc  (wb_cyc),
    .stb  (wb_stb),
    .we   (wb_we),
    .adr  (wb_adr),
    .ack  (wb_ack),
    .wr_go(wr_go),
    .rd_go(rd_go),
    .grp  (grp)
  );

  gpio_sync #(.W(NUM_LINES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_async(pad_in),
    .d_sync (pin_sync)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int GRP  = i / LANES;
    localparam int LANE = i % LANES;
    logic hit;

    assign hit = wr_go && (grp == GRP_W'(GRP)) && wb_sel[LANE];

    gpio_line u_line (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (hit),
      .wr_byte (wb_dat_w[LANE*CSR_W +: CSR_W]),
      .pin_sync(pin_sync[i]),
      .state   (st[i]),
      .rd_byte (rb[i])
    );

    assign pad_out[i] = st[i].io;
    assign pad_oe[i]  = st[i].oe;
    assign pad_pu[i]  = st[i].puen;
    assign pad_pd[i]  = st[i].pden;
    assign pad_bank[i*BANK_W +: BANK_W] = st[i].bank;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (grp == GRP_W'(i / LANES))
        rd_word[(i % LANES)*CSR_W +: CSR_W] = rb[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        wb_dat_r <= '0;
    else if (rd_go) wb_dat_r <= rd_word;
  end

endmodule

// File: rtl/gpio_csr_bank_chk.sv
module gpio_csr_bank_chk #(
  parameter int NUM_LINES = 16,
  parameter int DATA_W    = 64,
  localparam int LANES    = DATA_W / 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wb_cyc,
  input logic                   wb_stb,
  input logic                   wb_we,
  input logic [LANES-1:0]       wb_sel,
  input logic                   wb_ack,
  input logic [NUM_LINES-1:0]   pad_out,
  input logic [NUM_LINES-1:0]   pad_oe,
  input logic [NUM_LINES-1:0]   pad_pu,
  input logic [NUM_LINES-1:0]   pad_pd,
  input logic [3*NUM_LINES-1:0] pad_bank
);

  logic [6*NUM_LINES-1:0] pads;
  assign pads = {pad_out, pad_oe, pad_pu, pad_pd, pad_bank};

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!wb_ack && pads == '0)); // R1

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && wb_stb && !wb_ack) |=> wb_ack); // R2

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack); // R2

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    wb_ack |-> $past(wb_cyc && wb_stb)); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !(wb_cyc && wb_stb) |=> $stable(pads)); // R11

  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && wb_stb && !wb_we) |=> $stable(pads)); // R11

  AST_NO_LANE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && wb_stb && wb_we && wb_sel == '0) |=> $stable(pads)); // R8

endmodule

bind gpio_csr_bank gpio_csr_bank_chk #(
  .NUM_LINES(NUM_LINES),
  .DATA_W   (DATA_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wb_cyc  (wb_cyc),
  .wb_stb  (wb_stb),
  .wb_we   (wb_we),
  .wb_sel  (wb_sel),
  .wb_ack  (wb_ack),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .pad_pu  (pad_pu),
  .pad_pd  (pad_pd),
  .pad_bank(pad_bank)
);

// File: tb/gpio_csr_bank_bench.sv
module gpio_csr_bank_bench;

  localparam int NL = 12;
  localparam int DW = 64;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0;
  logic [AW-1:0] wb_adr = '0;
  logic [7:0]    wb_sel = '0;
  logic [DW-1:0] wb_dat_w = '0;
  logic [DW-1:0] wb_dat_r;
  logic          wb_ack;
  logic [NL-1:0] pad_in = '0;
  logic [NL-1:0] pad_out, pad_oe, pad_pu, pad_pd;
  logic [3*NL-1:0] pad_bank;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_csr_bank #(.NUM_LINES(NL), .DATA_W(DW), .ADDR_W(AW)) u_gpio_csr_bank (
    .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_sel(wb_sel), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r),
    .wb_ack(wb_ack), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_bank(pad_bank)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] s, input logic [DW-1:0] d);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = a; wb_sel = s; wb_dat_w = d;
    @(posedge clk); #1;
    check("R2 ack after write", 64'(wb_ack), 64'd1);
    @(negedge clk);
    wb_cyc = 0; wb_stb = 0; wb_we = 0; wb_sel = '0;
    @(posedge clk); #1;
    check("R2 ack one cycle", 64'(wb_ack), 64'd0);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = a;
    @(posedge clk); #1;
    check("R2 ack after read", 64'(wb_ack), 64'd1);
    d = wb_dat_r;
    @(negedge clk);
    wb_cyc = 0; wb_stb = 0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R1 pad_out", 64'(pad_out), 0);
    check("R1 pad_oe", 64'(pad_oe), 0);
    check("R1 pad_bank", 64'(pad_bank), 0);
    check("R1 ack", 64'(wb_ack), 0);
    bus_read(8'h00, d);
    check("R1 csr cleared", d, 0);
  endtask

  task automatic t_fields();
    logic [DW-1:0] d;
    bus_write(8'h00, 8'hFF, 64'h00000000_F01E49B5);
    check("R3 pad_out", 64'(pad_out), 64'h00D);
    check("R3 pad_oe", 64'(pad_oe), 64'h003);
    check("R3 pad_pu", 64'(pad_pu), 64'h005);
    check("R3 pad_pd", 64'(pad_pd), 64'h006);
    check("R3 pad_bank", 64'(pad_bank), 64'hE15);
    bus_read(8'h00, d);
    check("R4 R6 R7 readback group0", d, 64'h00000000_E00E49B5);
  endtask

  task automatic t_pad_input();
    logic [DW-1:0] d;
    @(negedge clk); pad_in = 12'h00C;
    repeat (3) @(posedge clk);
    bus_read(8'h00, d);
    check("R5 R4 R6 pad seen via IE", d, 64'h00000000_E01E49B5);
    @(negedge clk);
    pad_in = '0;
    wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = 8'h00;
    @(posedge clk); #1;
    check("R5 sync delay old level", wb_dat_r, 64'h00000000_E01E49B5);
    @(negedge clk); wb_cyc = 0; wb_stb = 0;
    repeat (3) @(posedge clk);
    bus_read(8'h00, d);
    check("R5 new level after sync", d, 64'h00000000_E00E49B5);
  endtask

  task automatic t_byte_sel();
    logic [DW-1:0] d;
    bus_write(8'h00, 8'h02, {DW{1'b1}});
    bus_read(8'h00, d);
    check("R8 only lane1 written", d, 64'h00000000_E00EFFB5);
    check("R8 pad_pu", 64'(pad_pu), 64'h007);
  endtask

  task automatic t_groups();
    logic [DW-1:0] d;
    bus_write(8'h08, 8'hFF, 64'hFFFFFFFF_00000021);
    bus_read(8'h0B, d);
    check("R9 R10 group1 readback", d, 64'h00000000_00000021);
    check("R9 line8 bank", 64'(pad_bank[26:24]), 64'd1);
    check("R9 pad_oe", 64'(pad_oe), 64'h103);
    bus_read(8'h05, d);
    check("R9 R10 group0 untouched", d, 64'h00000000_E00EFFB5);
    bus_read(8'h10, d);
    check("R10 empty group reads zero", d, 0);
  endtask

  task automatic t_idle();
    logic [DW-1:0] d;
    @(negedge clk);
    wb_cyc = 0; wb_stb = 1; wb_we = 1; wb_adr = 8'h00; wb_sel = 8'hFF; wb_dat_w = '0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      check("R11 no ack without cyc", 64'(wb_ack), 0);
    end
    @(negedge clk); wb_stb = 0; wb_we = 0; wb_sel = '0;
    check("R11 pad_oe held", 64'(pad_oe), 64'h103);
    bus_read(8'h00, d);
    check("R11 csr held", d, 64'h00000000_E00EFFB5);
  endtask

  task automatic t_reset_again();
    logic [DW-1:0] d;
    @(negedge clk); rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    check("R1 pads cleared", 64'({pad_out, pad_oe, pad_pu, pad_pd}), 0);
    check("R1 bank cleared", 64'(pad_bank), 0);
    bus_read(8'h08, d);
    check("R1 group1 cleared", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_fields();
    t_pad_input();
    t_byte_sel();
    t_groups();
    t_idle();
    t_reset_again();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule